// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns register writes from processors into inter-processor interrupts. A processor writes a generation word that names an interrupt number from 0 to 15, a target filter and an optional list of target processors. The block then marks that interrupt pending on each chosen target, and records which processor raised it. Pending state is held as one bit for each triple of target processor, interrupt number and source processor. Up to eight processors are supported. The number actually built is set by the parameter `NCPU`, which defaults to 4.

Each processor also sees two word views of its own pending state, one for setting and one for clearing. In each view a word covers four interrupt numbers, one byte each, with one bit per source processor. A target drops one pending bit when it takes the interrupt by pulsing the acknowledge input. The block drives a per-target, per-interrupt pending summary and a per-target "any pending" line.

The write port takes one write per cycle. It has no ready signal and never applies back-pressure. Every write that is presented is decoded in the cycle it appears, and its effect is visible after the next rising clock edge. Reads are combinational from the stored state.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset, every pending bit is clear, so `pend_o`, `irq_o` and all view reads return zero.
- R2: A write to byte address 0xF00 is a generation request, decoded from these fields of `wr_data`:
  - bits [3:0] give the interrupt number;
  - bits [23:16] give the target list;
  - bits [25:24] give the filter.
  
  With filter 0, the interrupt becomes pending on each processor whose list bit is set, with the writer (`wr_cpu`) as the source.
- R3: With filter 1, the interrupt becomes pending on every implemented processor except the writer. The writer's own pending state does not change.
- R4: With filter 2, the interrupt becomes pending only on the writer, with the writer as the source.
- R5: Filter 3 is reserved. A generation write that uses it changes no pending state.
- R6: The following are ignored:
  - target-list bits for processors at or above `NCPU`;
  - writes whose `wr_cpu` is at or above `NCPU`;
  - acknowledges whose `ack_cpu` or `ack_src` is at or above `NCPU`.
- R7: A write to the set view at 0xF20 + 4*k acts only on the writer's own pending state. For each bit of byte j with index b, a 1 sets pending for interrupt 4*k+j from source b. A 0 has no effect.
- R8: A write to the clear view at 0xF10 + 4*k uses the same layout as the set view. Each 1 bit clears pending for that interrupt and source on the writer only. A 0 has no effect.
- R9: `rd_data` returns the pending state of processor `rd_cpu` in the view layout. A read of 0xF10 + 4*k and a read of 0xF20 + 4*k return the same value. Bits for sources at or above `NCPU` read 0, and every other address reads 0.
- R10: An acknowledge clears exactly one bit: target `ack_cpu`, interrupt `ack_sgi`, source `ack_src`. Other sources of the same interrupt stay pending.
- R11: `pend_o[t*16+s]` is the OR over all sources of target t's pending bits for interrupt s. `irq_o[t]` is the OR over all of target t's pending bits.
- R12: When a set and a clear hit the same pending bit in the same cycle, the set wins and the bit ends up pending.
- R13: Pending state holds when there is no write and no acknowledge. Writes to any other address, including 0xF04, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 12 | Byte address of the write |
| wr_data | input | 32 | Write data |
| wr_cpu | input | 3 | Index of the writing processor |
| rd_addr | input | 12 | Byte address of the read |
| rd_cpu | input | 3 | Index of the reading processor |
| rd_data | output | 32 | Read data, combinational |
| ack_en | input | 1 | Acknowledge strobe |
| ack_cpu | input | 3 | Acknowledging target processor |
| ack_sgi | input | 4 | Acknowledged interrupt number |
| ack_src | input | 3 | Source processor being acknowledged |
| pend_o | output | NCPU*16 | Per-target, per-interrupt pending summary |
| irq_o | output | NCPU | Per-target any-pending line |

## Verification
The hardest situation to reach is a same-cycle collision: a generation write sets the very bit that an acknowledge is clearing. The bench first makes the bit pending. It then drives the self-only generation write and the matching acknowledge in the same cycle, and afterwards repeats the acknowledge alone to show the bit can still be cleared. Out-of-range processor indices are the other case that is hard to reach from the ports. The bench chooses an acknowledge index whose low bits alias a processor that really is pending, so an index that is truncated rather than rejected shows up as a lost bit.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int CPU_MAX  = 8;
  localparam int CPU_ID_W = 3;
  localparam int SGI_ID_W = 4;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;

  // byte offsets of the register window
  localparam int GEN_OFS  = 32'hF00;
  localparam int CLR_BASE = 32'hF10;
  localparam int SET_BASE = 32'hF20;

  // generation word field positions
  localparam int LIST_LSB = 16;
  localparam int FILT_LSB = 24;

  typedef enum logic [1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_RSVD   = 2'd3
  } filt_e;
endpackage

// File: rtl/sgi_req_decode.sv
module sgi_req_decode
  import sgi_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int NSGI = 16
) (
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [CPU_ID_W-1:0]          wr_cpu,
  output logic [NCPU*NSGI*NCPU-1:0]    set_vec,
  output logic [NCPU*NSGI*NCPU-1:0]    clr_vec
);
  localparam int VW = (NSGI + 3) / 4;

  logic            cpu_ok;
  logic            gen_hit;
  logic [NCPU-1:0] self_oh;
  logic [NCPU-1:0] tgt;
  logic [NSGI-1:0] id_oh;
  logic [VW-1:0]   set_hit;
  logic [VW-1:0]   clr_hit;
  filt_e           filt;
  logic            unused_data;

  assign unused_data = ^wr_data;
  assign cpu_ok  = int'(wr_cpu) < NCPU;
  assign gen_hit = wr_en && cpu_ok && (int'(wr_addr) == GEN_OFS);
  assign filt    = filt_e'(wr_data[FILT_LSB +: 2]);

  always_comb begin
    for (int c = 0; c < NCPU; c++) self_oh[c] = (int'(wr_cpu) == c);
    for (int s = 0; s < NSGI; s++) id_oh[s] = (int'(wr_data[SGI_ID_W-1:0]) == s);
  end

  always_comb begin
    case (filt)
      FLT_LIST:   tgt = wr_data[LIST_LSB +: NCPU];
      FLT_OTHERS: tgt = ~self_oh;
      FLT_SELF:   tgt = self_oh;
      default:    tgt = '0;
    endcase
  end

  for (genvar k = 0; k < VW; k++) begin : g_word
    assign set_hit[k] = wr_en && cpu_ok && (int'(wr_addr) == SET_BASE + 4 * k);
    assign clr_hit[k] = wr_en && cpu_ok && (int'(wr_addr) == CLR_BASE + 4 * k);
  end

  for (genvar t = 0; t < NCPU; t++) begin : g_tgt
    for (genvar s = 0; s < NSGI; s++) begin : g_sgi
      for (genvar src = 0; src < NCPU; src++) begin : g_src
        localparam int IDX = (t * NSGI + s) * NCPU + src;
        localparam int BIT = 8 * (s % 4) + src;
        assign set_vec[IDX] = (gen_hit & tgt[t] & id_oh[s] & self_oh[src]) |
                              (self_oh[t] & set_hit[s / 4] & wr_data[BIT]);
        assign clr_vec[IDX] = self_oh[t] & clr_hit[s / 4] & wr_data[BIT];
      end
    end
  end
endmodule

// File: rtl/sgi_pend_bank.sv
module sgi_pend_bank #(
  parameter int NCPU = 4,
  parameter int NSGI = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCPU*NSGI*NCPU-1:0] set_i,
  input  logic [NCPU*NSGI*NCPU-1:0] clr_i,
  output logic [NCPU*NSGI*NCPU-1:0] pend_q,
  output logic [NCPU*NSGI-1:0]      pend_o,
  output logic [NCPU-1:0]           irq_o
);
  // a set on the same bit as a clear takes precedence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | set_i;
  end

  for (genvar t = 0; t < NCPU; t++) begin : g_tgt
    for (genvar s = 0; s < NSGI; s++) begin : g_sgi
      assign pend_o[t * NSGI + s] = |pend_q[(t * NSGI + s) * NCPU +: NCPU];
    end
    assign irq_o[t] = |pend_o[t * NSGI +: NSGI];
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i))); // R12

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0)); // R8
endmodule

// File: rtl/sgi_view_read.sv
module sgi_view_read
  import sgi_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int NSGI = 16
) (
  input  logic [NCPU*NSGI*NCPU-1:0] pend_q,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic [CPU_ID_W-1:0]       rd_cpu,
  output logic [DATA_W-1:0]         rd_data
);
  localparam int VW = (NSGI + 3) / 4;

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < VW; k++) begin
      if (int'(rd_addr) == CLR_BASE + 4 * k || int'(rd_addr) == SET_BASE + 4 * k) begin
        for (int j = 0; j < 4; j++) begin
          for (int t = 0; t < NCPU; t++) begin
            for (int src = 0; src < NCPU; src++) begin
              if ((4 * k + j) < NSGI && int'(rd_cpu) == t)
                rd_data[8 * j + src] = pend_q[(t * NSGI + 4 * k + j) * NCPU + src];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int NSGI = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [CPU_ID_W-1:0]    wr_cpu,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [CPU_ID_W-1:0]    rd_cpu,
  output logic [DATA_W-1:0]      rd_data,
  input  logic                   ack_en,
  input  logic [CPU_ID_W-1:0]    ack_cpu,
  input  logic [SGI_ID_W-1:0]    ack_sgi,
  input  logic [CPU_ID_W-1:0]    ack_src,
  output logic [NCPU*NSGI-1:0]   pend_o,
  output logic [NCPU-1:0]        irq_o
);
  localparam int PW = NCPU * NSGI * NCPU;

  logic [PW-1:0] set_vec, clr_vec, ack_vec, pend_q;

  sgi_req_decode #(.NCPU(NCPU), .NSGI(NSGI)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_cpu(wr_cpu),
    .set_vec(set_vec), .clr_vec(clr_vec)
  );

  // acknowledge: clears one (target, interrupt, source) bit
  for (genvar t = 0; t < NCPU; t++) begin : g_ack_t
    for (genvar s = 0; s < NSGI; s++) begin : g_ack_s
      for (genvar src = 0; src < NCPU; src++) begin : g_ack_src
        assign ack_vec[(t * NSGI + s) * NCPU + src] = ack_en &&
          (int'(ack_cpu) == t) && (int'(ack_sgi) == s) && (int'(ack_src) == src);
      end
    end
  end

  sgi_pend_bank #(.NCPU(NCPU), .NSGI(NSGI)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec | ack_vec),
    .pend_q(pend_q), .pend_o(pend_o), .irq_o(irq_o)
  );

  sgi_view_read #(.NCPU(NCPU), .NSGI(NSGI)) u_rd (
    .pend_q(pend_q), .rd_addr(rd_addr), .rd_cpu(rd_cpu), .rd_data(rd_data)
  );

  logic gen_req;
  assign gen_req = wr_en && (int'(wr_addr) == GEN_OFS) && !ack_en;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !ack_en) |=> $stable(pend_o)); // R13

  AST_RSVD_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_req && wr_data[FILT_LSB +: 2] == 2'd3) |=> $stable(pend_o)); // R5

  AST_SELF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_req && wr_data[FILT_LSB +: 2] == 2'd2) |=>
      ($countones(pend_o ^ $past(pend_o)) <= 1)); // R4

  for (genvar c = 0; c < NCPU; c++) begin : g_chk_others
    AST_OTHERS_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_req && wr_data[FILT_LSB +: 2] == 2'd1 && int'(wr_cpu) == c) |=>
        $stable(pend_o[c * NSGI +: NSGI])); // R3
  end
endmodule

// File: tb/sgi_dispatch_bench.sv
`timescale 1ns/1ps
module sgi_dispatch_bench;
  localparam int NC = 4;
  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  wr_cpu = '0;
  logic [11:0] rd_addr = '0;
  logic [2:0]  rd_cpu = '0;
  logic [31:0] rd_data;
  logic        ack_en = 1'b0;
  logic [2:0]  ack_cpu = '0;
  logic [3:0]  ack_sgi = '0;
  logic [2:0]  ack_src = '0;
  logic [NC*NS-1:0] pend_o;
  logic [NC-1:0]    irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit m [0:NC-1][0:NS-1][0:NC-1];

  always #4 clk = ~clk;

  sgi_dispatch #(.NCPU(NC), .NSGI(NS)) u_sgi_dispatch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_cpu(wr_cpu), .rd_addr(rd_addr), .rd_cpu(rd_cpu), .rd_data(rd_data),
    .ack_en(ack_en), .ack_cpu(ack_cpu), .ack_sgi(ack_sgi), .ack_src(ack_src),
    .pend_o(pend_o), .irq_o(irq_o)
  );

  task automatic step(input bit we, input logic [11:0] a, input logic [31:0] d,
                      input logic [2:0] c, input bit ae, input logic [2:0] acpu,
                      input logic [3:0] asgi, input logic [2:0] asrc);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; wr_cpu = c;
    ack_en = ae; ack_cpu = acpu; ack_sgi = asgi; ack_src = asrc;
    @(negedge clk);
    wr_en = 1'b0; ack_en = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [2:0] c);
    step(1'b1, a, d, c, 1'b0, 3'd0, 4'd0, 3'd0);
  endtask

  task automatic ack(input logic [2:0] acpu, input logic [3:0] asgi, input logic [2:0] asrc);
    step(1'b0, 12'h0, 32'h0, 3'd0, 1'b1, acpu, asgi, asrc);
  endtask

  task automatic check_all(input string tag);
    logic [NC*NS-1:0] ep;
    logic [NC-1:0]    ei;
    ep = '0; ei = '0;
    for (int t = 0; t < NC; t++)
      for (int s = 0; s < NS; s++)
        for (int r = 0; r < NC; r++)
          if (m[t][s][r]) begin ep[t*NS+s] = 1'b1; ei[t] = 1'b1; end
    checks++;
    if (pend_o !== ep) begin
      failures++;
      $display("FAIL %s pend_o act=%h exp=%h", tag, pend_o, ep);
    end
    checks++;
    if (irq_o !== ei) begin
      failures++;
      $display("FAIL R11 (%s) irq_o act=%b exp=%b", tag, irq_o, ei);
    end
  endtask

  task automatic check_rd(input logic [11:0] a, input logic [2:0] c,
                          input logic [31:0] exp, input string tag);
    rd_addr = a; rd_cpu = c;
    #1;
    checks++;
    if (rd_data !== exp) begin
      failures++;
      $display("FAIL %s rd_data[%h] cpu%0d act=%h exp=%h", tag, a, c, rd_data, exp);
    end
  endtask

  task automatic t_reset();
    check_all("R1");
    check_rd(12'hF10, 3'd0, 32'h0, "R1");
  endtask

  task automatic t_list();
    // filter 0, list 0xF5 from cpu1, id 5: targets 0 and 2; bits 4..7 ignored (R6)
    wr(12'hF00, 32'h00F5_0005, 3'd1);
    m[0][5][1] = 1; m[2][5][1] = 1;
    check_all("R2");
    check_rd(12'hF14, 3'd2, 32'h0000_0200, "R9");
    check_rd(12'hF24, 3'd2, 32'h0000_0200, "R9");
  endtask

  task automatic t_others();
    wr(12'hF00, 32'h0100_0000, 3'd2);
    m[0][0][2] = 1; m[1][0][2] = 1; m[3][0][2] = 1;
    check_all("R3");
    check_rd(12'hF10, 3'd3, 32'h0000_0004, "R3");
    check_rd(12'hF10, 3'd2, 32'h0000_0000, "R3");
  endtask

  task automatic t_self();
    wr(12'hF00, 32'h0200_000F, 3'd3);
    m[3][15][3] = 1;
    check_all("R4");
    check_rd(12'hF1C, 3'd3, 32'h0800_0000, "R4");
  endtask

  task automatic t_rsvd();
    wr(12'hF00, 32'h03FF_0007, 3'd0);
    check_all("R5");
  endtask

  task automatic t_bad_cpu();
    wr(12'hF00, 32'h000F_0009, 3'd5);
    check_all("R6");
    ack(3'd5, 4'd0, 3'd2);   // aliases target 1 if truncated
    ack(3'd1, 4'd0, 3'd6);   // aliases source 2 if truncated
    check_all("R6");
  endtask

  task automatic t_setview();
    wr(12'hF28, 32'h0008_0042, 3'd0);
    m[0][8][1] = 1; m[0][10][3] = 1;
    check_all("R7");
    check_rd(12'hF28, 3'd0, 32'h0008_0002, "R9");
    check_rd(12'hF18, 3'd0, 32'h0008_0002, "R9");
  endtask

  task automatic t_clrview();
    wr(12'hF18, 32'h0000_0002, 3'd0);
    m[0][8][1] = 0;
    check_all("R8");
    wr(12'hF14, 32'h0000_0200, 3'd2);
    m[2][5][1] = 0;
    check_all("R8");
    check_rd(12'hF14, 3'd0, 32'h0000_0200, "R8");
  endtask

  task automatic t_ack();
    wr(12'hF20, 32'h0000_0001, 3'd1);
    m[1][0][0] = 1;
    ack(3'd1, 4'd0, 3'd2);
    m[1][0][2] = 0;
    check_all("R10");
    check_rd(12'hF10, 3'd1, 32'h0000_0001, "R10");
  endtask

  task automatic t_collide();
    wr(12'hF00, 32'h0200_0004, 3'd3);
    m[3][4][3] = 1;
    check_all("R4");
    step(1'b1, 12'hF00, 32'h0200_0004, 3'd3, 1'b1, 3'd3, 4'd4, 3'd3);
    check_all("R12");
    ack(3'd3, 4'd4, 3'd3);
    m[3][4][3] = 0;
    check_all("R10");
  endtask

  task automatic t_hold();
    wr(12'hF04, 32'hFFFF_FFFF, 3'd0);
    repeat (3) @(negedge clk);
    check_all("R13");
    check_rd(12'hF00, 3'd0, 32'h0, "R9");
  endtask

  initial begin
    for (int t = 0; t < NC; t++)
      for (int s = 0; s < NS; s++)
        for (int r = 0; r < NC; r++) m[t][s][r] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_list();
    t_others();
    t_self();
    t_rsvd();
    t_bad_cpu();
    t_setview();
    t_clrview();
    t_ack();
    t_collide();
    t_hold();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule